// File: doc/BRIEF.md
# Comparator Sample-Clock Divider with Asymmetric Duty

This block derives the sample clock for a successive-approximation comparator from the system clock. A 3-bit select picks one of eight divide ratios. The output stays high for most of each period, which gives the comparator's internal DAC time to settle before the low phase. At the fast ratios the high time is three quarters of the period. Some of those high times are a whole number of system-clock cycles plus one half, so the block uses both clock edges. At the slow ratios the high time is half the period plus three cycles, which is close to an even duty.

The clock runs only while the converter is enabled and its controller is out of idle. Each output period is announced by a one-cycle strobe, so the controller's state machine can advance in step with the comparator. The user picks the ratio that keeps the comparator clock at or below its limit (2 MHz) for the given system frequency.

Top module: `sar_clkdiv`

## Requirements
- R1: The select maps in ascending order to the divide ratio: 0→2, 1→4, 2→6, 3→8, 4→12, 5→16, 6→32, 7→64. The period between strobes is that ratio in system-clock cycles.
- R2: For selects 0 to 4, the output high time is three quarters of the period: 1.5, 3, 4.5, 6 and 9 system-clock cycles.
- R3: For selects 5, 6 and 7, the output high time is 11, 19 and 35 system-clock cycles.
- R4: The select is sampled only at the start of a period. A change in mid-period leaves the current period's length and high time unchanged, and it takes effect from the next period.
- R5: While stopped, with `idle` high or `en` low, the block produces no output pulse and no strobe.
- R6: Once `en` is high and `idle` is low while the block is stopped, the next rising system-clock edge starts a period: the output goes high and the strobe fires.
- R7: Reset is asynchronous. It drives the output and the strobe low and clears the period counter.
- R8: The strobe is high for exactly one system-clock cycle at the start of each period, in the same cycle that the output rises.
- R9: When `en` falls or `idle` rises during a period, that period completes in full, with its full high time. The output then stays low and no further strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sel | input | 3 | Divide-ratio select |
| en | input | 1 | Converter enable |
| idle | input | 1 | High while the controller is in its idle state |
| adc_clk | output | 1 | Divided comparator sample clock |
| period_stb | output | 1 | One-cycle strobe at the start of each period |

## Verification
The in-RTL properties check, on every cycle: that the counter stays inside the latched ratio, that the posedge high phase ends at the ratio's count, that the strobe lasts a single cycle and coincides with a high output, that no period starts while stopped, and that the latched select moves only at a period boundary. Only the bench's scenarios can show the whole-waveform results. These are the half-cycle extension of the high time measured at both edges, the exact strobe spacing for all eight ratios, a period completing in full after a mid-period stop, and a mid-period select change that takes effect one period later.

// File: rtl/sar_clkdiv.sv
module sar_clkdiv (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       en,
  input  logic       idle,
  output logic       adc_clk,
  output logic       period_stb
);
  localparam int CW = 7;

  function automatic logic [CW-1:0] period_of(input logic [2:0] s);
    case (s)
      3'd0: period_of = 7'd2;
      3'd1: period_of = 7'd4;
      3'd2: period_of = 7'd6;
      3'd3: period_of = 7'd8;
      3'd4: period_of = 7'd12;
      3'd5: period_of = 7'd16;
      3'd6: period_of = 7'd32;
      default: period_of = 7'd64;
    endcase
  endfunction

  // high time counted in half system-clock cycles
  function automatic logic [CW-1:0] high2_of(input logic [2:0] s);
    case (s)
      3'd0: high2_of = 7'd3;
      3'd1: high2_of = 7'd6;
      3'd2: high2_of = 7'd9;
      3'd3: high2_of = 7'd12;
      3'd4: high2_of = 7'd18;
      3'd5: high2_of = 7'd22;
      3'd6: high2_of = 7'd38;
      default: high2_of = 7'd70;
    endcase
  endfunction

  logic          run, high_p, neg_q, stb_q;
  logic [2:0]    sel_q;
  logic [CW-1:0] cnt;

  wire           go   = en & ~idle;
  wire [CW-1:0]  per  = period_of(sel_q);
  wire [CW-1:0]  h2   = high2_of(sel_q);
  wire [CW-1:0]  hf   = h2 >> 1;
  wire           half = h2[0];
  wire           bnd  = ~run | (cnt == per - 7'd1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run    <= 1'b0;
      high_p <= 1'b0;
      stb_q  <= 1'b0;
      sel_q  <= 3'd0;
      cnt    <= '0;
    end else begin
      stb_q <= 1'b0;
      if (bnd) begin
        cnt <= '0;
        if (go) begin
          run    <= 1'b1;
          sel_q  <= sel;
          high_p <= 1'b1;
          stb_q  <= 1'b1;
        end else begin
          run    <= 1'b0;
          high_p <= 1'b0;
        end
      end else begin
        cnt    <= cnt + 7'd1;
        high_p <= (cnt + 7'd1) < hf;
      end
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= high_p & half;
  end

  assign adc_clk    = high_p | neg_q;
  assign period_stb = stb_q;

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < per));

  p_high_phase_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(high_p) |-> (cnt == hf));

  p_sel_held_r4: assert property (@(posedge clk) disable iff (rst)
    !period_stb |-> $stable(sel_q));

  p_no_start_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !go) |=> !period_stb);

  p_strobe_high_r6: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> high_p);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb);
endmodule

// File: tb/sim_sar_clkdiv.sv
module sim_sar_clkdiv;
  localparam int T = 10;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, idle = 1'b1;
  logic [2:0] sel = 3'd0;
  logic adc_clk, period_stb;
  int nrun = 0, nfail = 0;
  bit a, b, st;

  sar_clkdiv u0 (.clk(clk), .rst(rst), .sel(sel), .en(en), .idle(idle),
                 .adc_clk(adc_clk), .period_stb(period_stb));

  always #(T/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    a = adc_clk; st = period_stb;
    #5;
    b = adc_clk;
  endtask

  function automatic int exp_per(input int s);
    if (s <= 3) return 2 * (s + 1);
    if (s == 4) return 12;
    return 1 << (s - 1);
  endfunction

  function automatic int exp_h2(input int p);
    return (p <= 12) ? (3 * p) / 2 : p + 6;
  endfunction

  task automatic quiet(input int n, input string req);
    int hi = 0, ns = 0;
    for (int i = 0; i < n; i++) begin
      step();
      hi += int'(a) + int'(b);
      ns += int'(st);
    end
    chk(hi == 0, req, hi, 0);
    chk(ns == 0, req, ns, 0);
  endtask

  task automatic run_sel(input int s);
    int per, h2, nstb, bad;
    int hc[3];
    per = exp_per(s); h2 = exp_h2(per); nstb = 0; bad = 0;
    hc[0] = 0; hc[1] = 0; hc[2] = 0;
    sel = 3'(s); en = 1'b1; idle = 1'b0;
    for (int i = 0; i < 3 * per; i++) begin
      step();
      if (i == 0) chk(a && st, "R6", int'(a) + int'(st), 2);
      if (st) begin
        nstb++;
        if (i % per != 0) bad++;
      end
      hc[i / per] += int'(a) + int'(b);
      if (i == 2 * per + 1) begin
        if (s[0]) en = 1'b0; else idle = 1'b1;
      end
    end
    chk(nstb == 3, "R8", nstb, 3);
    chk(bad == 0, "R1", bad, 0);
    for (int p = 0; p < 3; p++)
      chk(hc[p] == h2, (s < 5) ? "R2" : "R3", hc[p], h2);
    quiet(140, "R9");
  endtask

  initial begin
    #(T * 200000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(adc_clk == 1'b0, "R7", int'(adc_clk), 0);
    chk(period_stb == 1'b0, "R7", int'(period_stb), 0);
    rst = 1'b0;
    en = 1'b1; idle = 1'b1;
    quiet(100, "R5");
    en = 1'b0; idle = 1'b0;
    quiet(20, "R5");

    for (int s = 0; s < 8; s++) run_sel(s);

    // R4: select changes in mid-period, applies one period later
    begin
      int hc0, bad, nstb;
      hc0 = 0; bad = 0; nstb = 0;
      sel = 3'd7; en = 1'b1; idle = 1'b0;
      for (int i = 0; i < 68; i++) begin
        step();
        if (i == 5) sel = 3'd0;
        if (i < 64) hc0 += int'(a) + int'(b);
        if (st) begin
          nstb++;
          if (i != 0 && i != 64 && i != 66) bad++;
        end
      end
      chk(hc0 == 70, "R4", hc0, 70);
      chk(bad == 0, "R4", bad, 0);
      chk(nstb == 3, "R4", nstb, 3);
      idle = 1'b1;
      repeat (4) step();
      quiet(20, "R9");
    end

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule